// File: doc/BRIEF.md
# Cascaded Edge/Pattern Sequence Trigger

This block is the trigger engine of a parallel bus monitor. Every clock it takes one sample of a vector of bus signals. It works through a chain of up to five stages, where each stage waits for its own condition. The condition is a transition of a chosen polarity on one selected signal, a masked match of the whole sample against a value, or both in the same cycle. When the active stage sees its condition, the next used stage takes over in the following cycle. When the last used stage matches, the block issues a one-cycle trigger pulse and then holds until it is rearmed.

The physical last stage has extra qualifiers for time. A saturating timer counts sample clocks from the first cycle in which the last stage is active. The pattern compare of that stage is widened by three status bits: minimum time reached, maximum time reached and edge detected. Caring about these bits gives the combined conditions "edge and pattern", "before a maximum time" and "after a minimum time". Stages configured as pass-through are skipped, so a shorter sequence fires from its last used stage.

Top module: `seq_trigger`

## Requirements
- R1: After synchronous reset `stage_o` is 0 and `trig_o` is 0.
- R2: `stage_o` encodes the state as follows: 0 is idle, k in 1..NSTAGE means stage k-1 is waiting, and NSTAGE+1 means triggered. While idle, `arm` high in a cycle makes `stage_o` show the first used stage in the next cycle. `arm` has no effect in any other state.
- R3: Edge condition: `edge_sel` picks one signal, and `edge_pol` selects 1 for rising, 2 for falling, 3 for either and 0 for never. The transition is taken between the previous sample and the current one. No edge is seen in the first sample after reset.
- R4: Pattern condition: it holds when `((sig ^ pat_val) & pat_care) == 0`. Bits with a care bit of 0 are ignored.
- R5: Stage modes per 2-bit field are 0 pass, 1 edge, 2 pattern and 3 edge and pattern in the same cycle. The waiting stage is evaluated every cycle. On a match, `stage_o` shows the next used stage one cycle later, and an event in the matching cycle does not count for that next stage.
- R6: Mode-0 stages are skipped, both at arming and after a match. If no used stage follows, the trigger fires. If all stages are pass-through, arming fires at once.
- R7: `trig_o` is high for exactly the one cycle in which `stage_o` first shows NSTAGE+1. The block then stays triggered, with no further pulses, until `rearm`.
- R8: `rearm` returns the block to idle in the next cycle from any state, with priority over `arm` and over any match.
- R9: The pattern compare of the last stage is widened by three status bits above the signal bits. Bit SIG_W is set when the timer is at least `tmin`, bit SIG_W+1 when it is at least `tmax`, and bit SIG_W+2 when the last stage's edge condition is true. These bits are compared with `fin_xval` under the mask `fin_xcare`.
- R10: The timer reads 0 in the first cycle the last stage is waiting and rises by one each further cycle. It saturates at its all-ones value and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sig | input | SIG_W | Sampled bus signals |
| arm | input | 1 | Starts the sequence when idle |
| rearm | input | 1 | Synchronous return to idle |
| stg_mode | input | 2*NSTAGE | Per-stage mode: 0 pass, 1 edge, 2 pattern, 3 both |
| edge_sel | input | SEL_W*NSTAGE | Per-stage signal index for the edge detector |
| edge_pol | input | 2*NSTAGE | Per-stage polarity: 0 never, 1 rise, 2 fall, 3 any |
| pat_val | input | SIG_W*NSTAGE | Per-stage pattern value |
| pat_care | input | SIG_W*NSTAGE | Per-stage care mask |
| fin_xval | input | 3 | Last-stage status bit values {edge, max, min} |
| fin_xcare | input | 3 | Last-stage status bit care mask |
| tmin | input | TMR_W | Minimum elapsed time |
| tmax | input | TMR_W | Maximum elapsed time |
| trig_o | output | 1 | One-cycle trigger pulse |
| stage_o | output | IDX_W | Idle, waiting stage or triggered code |

## Verification
The hardest situation to reach from the ports is timer saturation in the last stage. With the default width it takes hundreds of cycles of waiting without a match. Only a "before maximum" condition that becomes true again after a wrap would reveal a wrapping counter. The bench reaches it with a directed run that parks the sequence in the last stage for longer than the counter range and then presents the pattern. A second directed case presents an event that matches a stage and its successor in the same cycle. The random batches mix sparse masks, single-bit toggles and random arm and rearm, and compare every cycle against a bench model.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_EDGE = 2'd1,
    MODE_PAT  = 2'd2,
    MODE_BOTH = 2'd3
  } stage_mode_e;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_RISE = 2'd1,
    POL_FALL = 2'd2,
    POL_ANY  = 2'd3
  } edge_pol_e;

  // status bits appended above the signals in the last stage compare
  localparam int XB_MIN  = 0;
  localparam int XB_MAX  = 1;
  localparam int XB_EDGE = 2;
  localparam int XB_W    = 3;
endpackage

// File: rtl/seqtrig_edge.sv
module seqtrig_edge
  import seqtrig_pkg::*;
#(
  parameter int SIG_W = 8,
  parameter int SEL_W = $clog2(SIG_W)
) (
  input  logic [SIG_W-1:0] cur,
  input  logic [SIG_W-1:0] prev,
  input  logic             valid,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       pol,
  output logic             hit
);
  logic now_b, old_b;

  always_comb begin
    now_b = cur[sel];
    old_b = prev[sel];
    case (pol)
      POL_RISE: hit = valid & now_b & ~old_b;
      POL_FALL: hit = valid & ~now_b & old_b;
      POL_ANY:  hit = valid & (now_b ^ old_b);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/seqtrig_pat.sv
module seqtrig_pat #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec,
  input  logic [W-1:0] val,
  input  logic [W-1:0] care,
  output logic         hit
);
  assign hit = ((vec ^ val) & care) == '0;
endmodule

// File: rtl/seqtrig_timer.sv
module seqtrig_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [TMR_W-1:0] tmin,
  input  logic [TMR_W-1:0] tmax,
  output logic             min_hit,
  output logic             max_hit
);
  localparam logic [TMR_W-1:0] TOP = '1;

  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign min_hit = cnt >= tmin;
  assign max_hit = cnt >= tmax;

  // R10: counter sticks at its top value while running
  a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == TOP) |=> (cnt == TOP));
  // R10: counter steps by one below the top
  a_r10_step: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));
  // R10: counter is held at zero outside the last stage
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/seq_trigger.sv
module seq_trigger
  import seqtrig_pkg::*;
#(
  parameter int SIG_W  = 8,
  parameter int NSTAGE = 5,
  parameter int TMR_W  = 8,
  localparam int SEL_W = $clog2(SIG_W),
  localparam int IDX_W = $clog2(NSTAGE + 2)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SIG_W-1:0]        sig,
  input  logic                    arm,
  input  logic                    rearm,
  input  logic [2*NSTAGE-1:0]     stg_mode,
  input  logic [SEL_W*NSTAGE-1:0] edge_sel,
  input  logic [2*NSTAGE-1:0]     edge_pol,
  input  logic [SIG_W*NSTAGE-1:0] pat_val,
  input  logic [SIG_W*NSTAGE-1:0] pat_care,
  input  logic [XB_W-1:0]         fin_xval,
  input  logic [XB_W-1:0]         fin_xcare,
  input  logic [TMR_W-1:0]        tmin,
  input  logic [TMR_W-1:0]        tmax,
  output logic                    trig_o,
  output logic [IDX_W-1:0]        stage_o
);
  localparam int LAST = NSTAGE - 1;
  localparam int DONE = NSTAGE + 1;
  localparam logic [IDX_W-1:0] CODE_DONE = IDX_W'(DONE);
  localparam logic [IDX_W-1:0] CODE_LAST = IDX_W'(NSTAGE);

  logic [SIG_W-1:0]  sig_q;
  logic              sig_vld;
  logic [IDX_W-1:0]  stage_r, stage_n;
  logic              trig_r, trig_n;
  logic [NSTAGE-1:0] hit_e, hit_p, hit;
  logic              min_hit, max_hit;

  // per-stage detectors
  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    seqtrig_edge #(.SIG_W(SIG_W), .SEL_W(SEL_W)) u_edge (
      .cur   (sig),
      .prev  (sig_q),
      .valid (sig_vld),
      .sel   (edge_sel[SEL_W*i +: SEL_W]),
      .pol   (edge_pol[2*i +: 2]),
      .hit   (hit_e[i])
    );

    if (i == LAST) begin : g_ext
      seqtrig_pat #(.W(SIG_W + XB_W)) u_pat (
        .vec  ({hit_e[i], max_hit, min_hit, sig}),
        .val  ({fin_xval, pat_val[SIG_W*i +: SIG_W]}),
        .care ({fin_xcare, pat_care[SIG_W*i +: SIG_W]}),
        .hit  (hit_p[i])
      );
    end else begin : g_plain
      seqtrig_pat #(.W(SIG_W)) u_pat (
        .vec  (sig),
        .val  (pat_val[SIG_W*i +: SIG_W]),
        .care (pat_care[SIG_W*i +: SIG_W]),
        .hit  (hit_p[i])
      );
    end

    always_comb begin
      case (stg_mode[2*i +: 2])
        MODE_EDGE: hit[i] = hit_e[i];
        MODE_PAT:  hit[i] = hit_p[i];
        MODE_BOTH: hit[i] = hit_e[i] & hit_p[i];
        default:   hit[i] = 1'b1;
      endcase
    end
  end

  seqtrig_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (stage_r == CODE_LAST),
    .tmin    (tmin),
    .tmax    (tmax),
    .min_hit (min_hit),
    .max_hit (max_hit)
  );

  // code of the first stage at or after 'from' that is not pass-through
  function automatic logic [IDX_W-1:0] first_used(input int from);
    logic [IDX_W-1:0] res;
    logic             found;
    res   = CODE_DONE;
    found = 1'b0;
    for (int j = 0; j < NSTAGE; j++) begin
      if (!found && j >= from && stg_mode[2*j +: 2] != MODE_PASS) begin
        res   = IDX_W'(j + 1);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  always_comb begin
    stage_n = stage_r;
    if (rearm) begin
      stage_n = '0;
    end else if (stage_r == '0) begin
      if (arm) stage_n = first_used(0);
    end else if (stage_r != CODE_DONE) begin
      for (int i = 0; i < NSTAGE; i++) begin
        if (stage_r == IDX_W'(i + 1) && hit[i]) stage_n = first_used(i + 1);
      end
    end
    trig_n = (stage_n == CODE_DONE) && (stage_r != CODE_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_r <= '0;
      trig_r  <= 1'b0;
      sig_q   <= '0;
      sig_vld <= 1'b0;
    end else begin
      stage_r <= stage_n;
      trig_r  <= trig_n;
      sig_q   <= sig;
      sig_vld <= 1'b1;
    end
  end

  assign trig_o  = trig_r;
  assign stage_o = stage_r;

  // R7: the trigger is a single-cycle pulse
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (rst)
    trig_r |=> !trig_r);
  // R7: the pulse coincides with the triggered code
  a_r7_done_code: assert property (@(posedge clk) disable iff (rst)
    trig_r |-> (stage_r == CODE_DONE));
  // R7: the triggered state is held until rearm
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (stage_r == CODE_DONE && !rearm) |=> (stage_r == CODE_DONE && !trig_r));
  // R8: rearm always returns to idle
  a_r8_rearm: assert property (@(posedge clk) disable iff (rst)
    rearm |=> (stage_r == '0 && !trig_r));
  // R5: the sequence only moves forward without rearm
  a_r5_forward: assert property (@(posedge clk) disable iff (rst)
    (!rearm && stage_r != '0) |=> (stage_r >= $past(stage_r)));
  // R2: idle is held without arm
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (stage_r == '0 && !arm && !rearm) |=> (stage_r == '0));
  // R2: the state code stays in range
  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    stage_r <= CODE_DONE);
endmodule

// File: tb/seq_trigger_test.sv
module seq_trigger_test;
  localparam int NS = 5;
  localparam int SW = 8;
  localparam int SLW = 3;
  localparam int TW = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] sig = '0;
  logic arm = 1'b0, rearm = 1'b0;
  logic [2*NS-1:0] stg_mode, edge_pol;
  logic [SLW*NS-1:0] edge_sel;
  logic [SW*NS-1:0] pat_val, pat_care;
  logic [2:0] fin_xval, fin_xcare;
  logic [TW-1:0] tmin, tmax;
  logic trig_o;
  logic [IW-1:0] stage_o;

  logic [1:0] c_mode [NS];
  logic [2:0] c_sel [NS];
  logic [1:0] c_pol [NS];
  logic [7:0] c_pat [NS];
  logic [7:0] c_mask [NS];
  logic [2:0] c_xval, c_xcare;
  logic [7:0] c_tmin, c_tmax;

  int checks = 0, errors = 0;
  string req = "R1";

  int m_st = 0;
  int m_trig = 0;
  int m_tmr = 0;
  logic [7:0] m_prev = '0;
  bit m_pv = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      stg_mode[2*i +: 2]   = c_mode[i];
      edge_pol[2*i +: 2]   = c_pol[i];
      edge_sel[SLW*i +: SLW] = c_sel[i];
      pat_val[SW*i +: SW]  = c_pat[i];
      pat_care[SW*i +: SW] = c_mask[i];
    end
    fin_xval  = c_xval;
    fin_xcare = c_xcare;
    tmin = c_tmin;
    tmax = c_tmax;
  end

  seq_trigger #(.SIG_W(SW), .NSTAGE(NS), .TMR_W(TW)) uut (
    .clk(clk), .rst(rst), .sig(sig), .arm(arm), .rearm(rearm),
    .stg_mode(stg_mode), .edge_sel(edge_sel), .edge_pol(edge_pol),
    .pat_val(pat_val), .pat_care(pat_care),
    .fin_xval(fin_xval), .fin_xcare(fin_xcare),
    .tmin(tmin), .tmax(tmax), .trig_o(trig_o), .stage_o(stage_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_edge(input int k, input logic [7:0] s);
    bit c, p;
    if (!m_pv) return 0;
    c = s[c_sel[k]];
    p = m_prev[c_sel[k]];
    case (c_pol[k])
      2'd1: return c && !p;
      2'd2: return !c && p;
      2'd3: return c != p;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_match(input int k, input logic [7:0] s);
    bit e, pt;
    logic [2:0] x;
    e = m_edge(k, s);
    pt = ((s ^ c_pat[k]) & c_mask[k]) == 8'h00;
    if (k == NS - 1) begin
      x = {e, m_tmr >= int'(c_tmax), m_tmr >= int'(c_tmin)};
      pt = pt && (((x ^ c_xval) & c_xcare) == 3'b000);
    end
    case (c_mode[k])
      2'd1: return e;
      2'd2: return pt;
      2'd3: return e && pt;
      default: return 1;
    endcase
  endfunction

  function automatic int m_used(input int from);
    for (int j = from; j < NS; j++) if (c_mode[j] != 2'd0) return j + 1;
    return NS + 1;
  endfunction

  task automatic model_step(input logic [7:0] s, input bit a, input bit r);
    int ost;
    ost = m_st;
    m_trig = 0;
    if (r) m_st = 0;
    else if (m_st == 0) begin
      if (a) m_st = m_used(0);
    end else if (m_st != NS + 1) begin
      if (m_match(m_st - 1, s)) m_st = m_used(m_st);
    end
    if (m_st == NS + 1 && ost != NS + 1) m_trig = 1;
    m_tmr = (ost == NS) ? ((m_tmr == 255) ? 255 : m_tmr + 1) : 0;
    m_prev = s;
    m_pv = 1;
  endtask

  task automatic cyc(input logic [7:0] s, input bit a, input bit r);
    sig = s; arm = a; rearm = r;
    model_step(s, a, r);
    @(posedge clk);
    @(negedge clk);
    chk({req, " stage"}, int'(stage_o), m_st);
    chk({req, " trig"}, int'(trig_o), m_trig);
  endtask

  task automatic cfg_clear;
    for (int i = 0; i < NS; i++) begin
      c_mode[i] = 2'd0; c_sel[i] = 3'd0; c_pol[i] = 2'd0;
      c_pat[i] = 8'h00; c_mask[i] = 8'h00;
    end
    c_xval = 3'b000; c_xcare = 3'b000; c_tmin = 8'd0; c_tmax = 8'd0;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    void'($urandom(32'd4242));
    cfg_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 stage", int'(stage_o), 0);
    chk("R1 trig", int'(trig_o), 0);
    rst = 1'b0;

    // R6: all stages pass-through, arming fires at once
    req = "R6";
    cyc(8'h00, 0, 0);
    cyc(8'h00, 1, 0);
    chk("R6 immediate trig", int'(trig_o), 1);
    req = "R7";
    cyc(8'h00, 1, 0);
    chk("R7 single pulse", int'(trig_o), 0);
    chk("R7 hold done", int'(stage_o), NS + 1);
    // R8: rearm beats arm
    req = "R8";
    cyc(8'h00, 1, 1);
    chk("R8 idle after rearm", int'(stage_o), 0);

    // R5: three used stages, shared event must not skip a stage
    req = "R5";
    cfg_clear();
    c_mode[0] = 2'd2; c_pat[0] = 8'hA5; c_mask[0] = 8'hFF;
    c_mode[2] = 2'd1; c_sel[2] = 3'd7; c_pol[2] = 2'd1;
    c_mode[4] = 2'd1; c_sel[4] = 3'd0; c_pol[4] = 2'd3;
    cyc(8'h00, 1, 0);
    chk("R2 first used stage", int'(stage_o), 1);
    cyc(8'hA5, 0, 0);
    chk("R5 skip to stage 3", int'(stage_o), 3);
    cyc(8'hA5, 1, 0);
    chk("R2 arm ignored when busy", int'(stage_o), 3);
    cyc(8'h25, 0, 0);
    cyc(8'hA5, 0, 0);
    chk("R5 rising reached last", int'(stage_o), 5);
    cyc(8'hA5, 0, 0);
    cyc(8'hA4, 0, 0);
    chk("R7 pulse after last", int'(trig_o), 1);
    cyc(8'hA5, 0, 0);
    chk("R7 no second pulse", int'(trig_o), 0);
    cyc(8'h00, 0, 1);

    // R3: polarity 0 never fires, falling works
    req = "R3";
    cfg_clear();
    c_mode[0] = 2'd1; c_sel[0] = 3'd2; c_pol[0] = 2'd0;
    cyc(8'h04, 1, 0);
    cyc(8'h00, 0, 0);
    cyc(8'h04, 0, 0);
    chk("R3 never polarity", int'(stage_o), 1);
    c_pol[0] = 2'd2;
    cyc(8'h04, 0, 0);
    cyc(8'h00, 0, 0);
    chk("R3 falling edge", int'(trig_o), 1);
    cyc(8'h00, 0, 1);

    // R4: don't-care bits ignored
    req = "R4";
    cfg_clear();
    c_mode[1] = 2'd2; c_pat[1] = 8'h09; c_mask[1] = 8'h0F;
    cyc(8'h00, 1, 0);
    cyc(8'hF8, 0, 0);
    chk("R4 care mismatch", int'(stage_o), 2);
    cyc(8'h79, 0, 0);
    chk("R4 masked match", int'(trig_o), 1);
    cyc(8'h00, 0, 1);

    // R5: mode 3 needs edge and pattern together
    req = "R5";
    cfg_clear();
    c_mode[0] = 2'd3; c_sel[0] = 3'd4; c_pol[0] = 2'd1;
    c_pat[0] = 8'h01; c_mask[0] = 8'h01;
    cyc(8'h00, 1, 0);
    cyc(8'h10, 0, 0);
    cyc(8'h01, 0, 0);
    cyc(8'h11, 0, 0);
    chk("R5 both condition", int'(trig_o), 1);
    cyc(8'h00, 0, 1);

    // R9/R10: after minimum time
    req = "R9";
    cfg_clear();
    c_mode[4] = 2'd2; c_xcare = 3'b001; c_xval = 3'b001; c_tmin = 8'd3;
    cyc(8'h00, 1, 0);
    chk("R9 entered last", int'(stage_o), 5);
    cyc(8'h00, 0, 0);
    cyc(8'h00, 0, 0);
    cyc(8'h00, 0, 0);
    chk("R10 before min held", int'(stage_o), 5);
    cyc(8'h00, 0, 0);
    chk("R10 min reached", int'(trig_o), 1);
    cyc(8'h00, 0, 1);

    // R9: before maximum time
    c_mask[4] = 8'hFF; c_pat[4] = 8'h3C;
    c_xcare = 3'b010; c_xval = 3'b000; c_tmax = 8'd2;
    cyc(8'h00, 1, 0);
    cyc(8'h00, 0, 0);
    cyc(8'h00, 0, 0);
    cyc(8'h3C, 0, 0);
    cyc(8'h3C, 0, 0);
    chk("R9 late pattern rejected", int'(stage_o), 5);
    cyc(8'h00, 0, 1);
    cyc(8'h00, 1, 0);
    cyc(8'h00, 0, 0);
    cyc(8'h3C, 0, 0);
    chk("R9 early pattern accepted", int'(trig_o), 1);
    cyc(8'h00, 0, 1);

    // R9: edge and pattern in the last stage
    c_mask[4] = 8'h40; c_pat[4] = 8'h40; c_sel[4] = 3'd1; c_pol[4] = 2'd1;
    c_xcare = 3'b100; c_xval = 3'b100;
    cyc(8'h00, 1, 0);
    cyc(8'h02, 0, 0);
    cyc(8'h40, 0, 0);
    chk("R9 edge without pattern", int'(stage_o), 5);
    cyc(8'h42, 0, 0);
    chk("R9 edge with pattern", int'(trig_o), 1);
    cyc(8'h00, 0, 1);

    // R10: saturation, a wrapping timer would reopen the window
    req = "R10";
    c_mask[4] = 8'hFF; c_pat[4] = 8'h3C;
    c_xcare = 3'b010; c_xval = 3'b000; c_tmax = 8'd10;
    cyc(8'h00, 1, 0);
    for (int n = 0; n < 265; n++) cyc(8'h00, 0, 0);
    cyc(8'h3C, 0, 0);
    cyc(8'h3C, 0, 0);
    chk("R10 saturated no wrap", int'(stage_o), 5);
    cyc(8'h00, 0, 1);

    // random batches against the model
    req = "R5 random";
    s = 8'h00;
    for (int b = 0; b < 40; b++) begin
      for (int i = 0; i < NS; i++) begin
        c_mode[i] = (($urandom % 3) == 0) ? 2'd0 : 2'($urandom % 4);
        c_sel[i] = 3'($urandom % 8);
        c_pol[i] = 2'($urandom % 4);
        c_pat[i] = 8'($urandom);
        c_mask[i] = 8'($urandom) & 8'($urandom) & 8'($urandom);
      end
      c_xval = 3'($urandom % 8); c_xcare = 3'($urandom % 8);
      c_tmin = 8'($urandom % 12); c_tmax = 8'($urandom % 12);
      cyc(s, 0, 1);
      for (int n = 0; n < 150; n++) begin
        if (($urandom % 4) == 0) s = 8'($urandom);
        else s = s ^ (8'h01 << ($urandom % 8));
        cyc(s, ($urandom % 4) == 0, ($urandom % 64) == 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule